// File: doc/BRIEF.md
# Double-Buffered Tuning Word Loader

This block sits in front of a numerically controlled oscillator and supplies its phase increment. A new increment is assembled in a shadow buffer through a narrow port. Software can shift it in one bit per strobe, most significant bit first. It can also write it one byte lane at a time.

A single update strobe copies the whole shadow buffer into the active increment register on one clock edge. The oscillator therefore never sees a half-written word. The block has no connection to the phase accumulator, so a frequency change never disturbs the running phase. A pending flag tells the loader that the buffer holds contents that have not yet been made active.

Filling the buffer takes 32 shift strobes in serial mode, or 4 lane writes in byte mode. That count sets the fastest rate at which the frequency can be retuned.

Top module: `tw_loader`

## Requirements
- R1: After reset, `tuning_word_o` is zero, `pending_o` is low, and the shadow buffer is zero, so an update issued before any write keeps the output at zero.
- R2: `tuning_word_o` changes only in the cycle after an `update_i` strobe. Buffer writes without an update never reach the output.
- R3: `update_i` copies the entire shadow buffer into the active register, and every bit of `tuning_word_o` takes its new value on the same clock edge, visible from the next cycle.
- R4: With `mode_i` = 0 (serial), each `ser_shift_i` strobe shifts the buffer left by one bit and places `ser_bit_i` in bit 0. 32 strobes load a word sent most significant bit first.
- R5: With `mode_i` = 1 (byte), each `byte_we_i` strobe writes `byte_data_i` into byte lane `byte_addr_i` of the buffer and leaves the other lanes unchanged. Lane 0 is bits 7:0, lane 1 is bits 15:8, lane 2 is bits 23:16 and lane 3 is bits 31:24.
- R6: Strobes of the mode not selected leave the buffer unchanged: `byte_we_i` while `mode_i` = 0, and `ser_shift_i` while `mode_i` = 1.
- R7: `pending_o` is high from the cycle after any buffer write that takes effect.
- R8: `update_i` clears `pending_o` in the following cycle, unless a buffer write takes effect in the same cycle, in which case `pending_o` stays high.
- R9: When `update_i` and a buffer write fall in the same cycle, the active register takes the buffer contents from before that write, and the write still lands in the buffer.
- R10: An update leaves the buffer contents in place, so a later update without any write loads the same word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Load mode: 0 serial, 1 byte |
| ser_bit_i | input | 1 | Serial data bit |
| ser_shift_i | input | 1 | Serial shift strobe |
| byte_data_i | input | 8 | Byte to write |
| byte_addr_i | input | 2 | Byte lane select, 0 = least significant |
| byte_we_i | input | 1 | Byte write strobe |
| update_i | input | 1 | Transfer buffer to active register |
| tuning_word_o | output | 32 | Active phase increment |
| pending_o | output | 1 | Buffer holds untransferred contents |

## Verification
The bench builds the block with its default parameters: a 32-bit word and 8-bit lanes, which gives four lanes addressed by two bits. These values bring the full 32-strobe serial load within reach, along with a write to each lane in both the lowest and highest positions. They also cover the collision of an update with a lane write, and the collision of an update with a serial shift, where the pre-write buffer must win. Wrong-mode strobes are driven and then exposed through a later update, so any leak into the buffer appears on the output.

// File: rtl/tw_loader_pkg.sv
package tw_loader_pkg;
  typedef enum logic {
    LOAD_SERIAL = 1'b0,
    LOAD_BYTE   = 1'b1
  } load_mode_e;
endpackage

// File: rtl/tw_shadow_buf.sv
module tw_shadow_buf
  import tw_loader_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  localparam int NUM_LANES = WORD_W / BYTE_W,
  localparam int ADDR_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  load_mode_e        mode_i,
  input  logic              ser_bit_i,
  input  logic              ser_shift_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic              byte_we_i,
  output logic [WORD_W-1:0] buf_o,
  output logic              wr_o
);
  logic [WORD_W-1:0] buf_q;
  logic [WORD_W-1:0] shifted;
  logic              shift_en;
  logic              lane_en;

  assign shift_en = ser_shift_i && (mode_i == LOAD_SERIAL);
  assign lane_en  = byte_we_i && (mode_i == LOAD_BYTE);
  assign shifted  = {buf_q[WORD_W-2:0], ser_bit_i};
  assign wr_o     = shift_en || lane_en;
  assign buf_o    = buf_q;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic sel;
    assign sel = lane_en && (byte_addr_i == ADDR_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q[g*BYTE_W +: BYTE_W] <= '0;
      end else if (shift_en) begin
        buf_q[g*BYTE_W +: BYTE_W] <= shifted[g*BYTE_W +: BYTE_W];
      end else if (sel) begin
        buf_q[g*BYTE_W +: BYTE_W] <= byte_data_i;
      end
    end
  end

  assert_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en |=> buf_q == {$past(buf_q[WORD_W-2:0]), $past(ser_bit_i)});

  assert_lane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_en |=> buf_q[$past(byte_addr_i)*BYTE_W +: BYTE_W] == $past(byte_data_i));

  assert_ignore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en && !lane_en |=> $stable(buf_q));
endmodule

// File: rtl/tw_active_reg.sv
module tw_active_reg #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              update_i,
  input  logic [WORD_W-1:0] buf_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  // all bits move together on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       word_q <= '0;
    else if (update_i) word_q <= buf_i;
  end

  assign word_o = word_q;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(word_q));
endmodule

// File: rtl/tw_pending.sv
module tw_pending (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic update_i,
  output logic pending_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (wr_i)     pend_q <= 1'b1;
    else if (update_i) pend_q <= 1'b0;
  end

  assign pending_o = pend_q;

  assert_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pend_q);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && !wr_i |=> !pend_q);
endmodule

// File: rtl/tw_loader.sv
module tw_loader
  import tw_loader_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  localparam int NUM_LANES = WORD_W / BYTE_W,
  localparam int ADDR_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              ser_bit_i,
  input  logic              ser_shift_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic              byte_we_i,
  input  logic              update_i,
  output logic [WORD_W-1:0] tuning_word_o,
  output logic              pending_o
);
  logic [WORD_W-1:0] buf_w;
  logic              wr_w;
  load_mode_e        mode_w;

  assign mode_w = load_mode_e'(mode_i);

  tw_shadow_buf #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_buf (
    .clk_i, .rst_ni,
    .mode_i     (mode_w),
    .ser_bit_i, .ser_shift_i,
    .byte_data_i, .byte_addr_i, .byte_we_i,
    .buf_o      (buf_w),
    .wr_o       (wr_w)
  );

  tw_active_reg #(.WORD_W(WORD_W)) u_act (
    .clk_i, .rst_ni,
    .update_i,
    .buf_i  (buf_w),
    .word_o (tuning_word_o)
  );

  tw_pending u_pend (
    .clk_i, .rst_ni,
    .wr_i     (wr_w),
    .update_i,
    .pending_o
  );

  // transfer takes the buffer as it stood before any same-cycle write
  assert_xfer_R3_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> tuning_word_o == $past(buf_w));
endmodule

// File: tb/tw_loader_tb.sv
module tw_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic        ser_bit = 1'b0;
  logic        ser_shift = 1'b0;
  logic [7:0]  bdata = '0;
  logic [1:0]  baddr = '0;
  logic        bwe = 1'b0;
  logic        upd = 1'b0;
  logic [31:0] word;
  logic        pend;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tw_loader u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .ser_bit_i(ser_bit), .ser_shift_i(ser_shift),
    .byte_data_i(bdata), .byte_addr_i(baddr), .byte_we_i(bwe),
    .update_i(upd), .tuning_word_o(word), .pending_o(pend)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock with the given strobes; starts and ends on a falling edge
  task automatic cyc(input logic m, input logic sb, input logic ss,
                     input logic [7:0] bd, input logic [1:0] ba,
                     input logic bw, input logic up);
    mode = m; ser_bit = sb; ser_shift = ss; bdata = bd; baddr = ba; bwe = bw; upd = up;
    @(negedge clk);
    ser_shift = 1'b0; bwe = 1'b0; upd = 1'b0;
  endtask

  task automatic do_update();
    cyc(mode, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    check("R1 word", word, 32'h0);
    check("R1 pending", {31'b0, pend}, 32'h0);
    do_update();
    check("R1 buffer zero", word, 32'h0);
  endtask

  task automatic t_serial();
    logic [31:0] w = 32'hA5C3_1E78;
    for (int i = 31; i >= 0; i--) cyc(1'b0, w[i], 1'b1, 8'h00, 2'd0, 1'b0, 1'b0);
    check("R7 pending after shifts", {31'b0, pend}, 32'h1);
    check("R2 output held", word, 32'h0);
    do_update();
    check("R4 serial word", word, w);
    check("R8 pending cleared", {31'b0, pend}, 32'h0);
  endtask

  task automatic t_bytes();
    cyc(1'b1, 1'b0, 1'b0, 8'h11, 2'd0, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 8'hEE, 2'd3, 1'b1, 1'b0);
    check("R2 held after byte writes", word, 32'hA5C3_1E78);
    do_update();
    check("R5 lanes 0 and 3", word, 32'hEEC3_1E11);
    cyc(1'b1, 1'b0, 1'b0, 8'h22, 2'd1, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 8'h33, 2'd2, 1'b1, 1'b0);
    do_update();
    check("R3 full word", word, 32'hEE33_2211);
  endtask

  task automatic t_ignore();
    cyc(1'b0, 1'b0, 1'b0, 8'hFF, 2'd2, 1'b1, 1'b0);
    cyc(1'b1, 1'b1, 1'b1, 8'h00, 2'd0, 1'b0, 1'b0);
    check("R6 no pending", {31'b0, pend}, 32'h0);
    do_update();
    check("R6 buffer unchanged", word, 32'hEE33_2211);
  endtask

  task automatic t_collision();
    cyc(1'b1, 1'b0, 1'b0, 8'h5A, 2'd0, 1'b1, 1'b1);
    check("R9 old buffer taken", word, 32'hEE33_2211);
    check("R8 pending kept", {31'b0, pend}, 32'h1);
    do_update();
    check("R9 write landed", word, 32'hEE33_225A);
    cyc(1'b0, 1'b1, 1'b1, 8'h00, 2'd0, 1'b0, 1'b1);
    check("R9 serial collision", word, 32'hEE33_225A);
    do_update();
    check("R4 shift after collision", word, 32'hDC66_44B5);
  endtask

  task automatic t_reupdate();
    do_update();
    check("R10 reload same", word, 32'hDC66_44B5);
    check("R10 pending low", {31'b0, pend}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_serial();
    t_bytes();
    t_ignore();
    t_collision();
    t_reupdate();
    done = 1;
  end

  initial begin
    int cnt = 0;
    while (!done && cnt < 100000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule